// File: doc/BRIEF.md
# Stack Pointer and Call/Return Unit

This block keeps the stack pointer of an 8-bit microcontroller core and runs the stack traffic for it. The stack lives in a 256-byte internal data RAM, which is modelled inside the block as a synchronous array. The core issues one command at a time: push a byte, pop a byte, call (save a 16-bit program counter) or return (restore it). The block drives the RAM address, write data and write enable as visible outputs. It hands back popped bytes and the restored program counter. Software can read the pointer at any time and overwrite it through a register port.

The pointer always names the byte that was stored last. A store first moves the pointer up by one and then writes there. A load first reads at the pointer and then moves it down by one. After reset the pointer holds 07h, so the first stored byte goes to 08h. A call stores the program counter as two bytes, low byte first. A return takes the high byte first and then the low byte.

The sequencer has three states. From ST_IDLE, an accepted call goes to ST_CALL_HI and an accepted return goes to ST_RET_LO. An accepted push or pop stays in ST_IDLE. ST_CALL_HI and ST_RET_LO always go back to ST_IDLE after one cycle. Reset enters ST_IDLE.

Top module: `stack_call_unit`

## Requirements
- R1: After reset the pointer reads 07h, and busy, pop-valid, return-valid and RAM write enable are all low.
- R2: An accepted push drives write enable with the address pointer+1 and the push byte in the same cycle. From the next cycle the pointer reads that address.
- R3: An accepted pop drives the address of the current pointer. The byte stored there appears on the pop data output with pop-valid high one cycle later, and the pointer drops by one.
- R4: The stack is last-in first-out: a run of pops returns the pushed bytes in reverse order, and the pointer names the last written byte.
- R5: An accepted call writes the program counter low byte at pointer+1 in the accept cycle. It writes the high byte at the next address in the following cycle. The pointer rises by two in total.
- R6: An accepted return reads the high byte at the pointer and then the low byte one address lower in the next cycle. The restored 16-bit value appears with return-valid high in the cycle after that, and the pointer falls by two.
- R7: Busy is high for exactly the one cycle that follows an accepted call or return. Any command presented while busy is high has no effect on the RAM, the pointer or the outputs.
- R8: The pointer wraps modulo 256: a push at FFh stores at 00h, and a pop at 00h leaves FFh. No flag is raised.
- R9: A register write to the pointer loads the written value and wins over the increment or decrement of a command in the same cycle. That command still makes its RAM access at the address formed from the old pointer. The register read port always shows the current pointer.
- R10: The 2-bit command code is 00 push, 01 pop, 10 call, 11 return, and a command is taken only when command-valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (R10) |
| push_data_i | input | 8 | Byte to push |
| pc_i | input | 16 | Program counter saved by a call |
| sp_wr_i | input | 1 | Software write strobe for the pointer |
| sp_wdata_i | input | 8 | Value loaded by a software write |
| sp_rdata_o | output | 8 | Current pointer value |
| ram_addr_o | output | 8 | Stack RAM address |
| ram_wdata_o | output | 8 | Stack RAM write data |
| ram_we_o | output | 1 | Stack RAM write enable |
| pop_data_o | output | 8 | Popped byte, valid with pop_vld_o |
| pop_vld_o | output | 1 | Popped byte valid |
| ret_pc_o | output | 16 | Restored program counter, valid with ret_vld_o |
| ret_vld_o | output | 1 | Restored program counter valid |
| busy_o | output | 1 | Second cycle of a call or return in progress |

## Verification
The collision that matters is a software load of the pointer in the same cycle as a stack command. The load must set the pointer, while the command still reads or writes at the address formed from the old value. The bench provokes this directly: it loads during a push, and it loads during the second cycle of a call. Random traffic then adds loads at about one cycle in sixteen. A behavioural reference model applies the rule in R9 and is compared with the pointer, the RAM address and data, and the returned values on every clock. A second overlap is a command that arrives while a call or return is still in its second cycle. Here the model expects no change at all.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_CALL_HI = 2'b01,
        ST_RET_LO  = 2'b10
    } stk_state_e;

    typedef enum logic [1:0] {
        WSEL_DATA  = 2'b00,
        WSEL_PC_LO = 2'b01,
        WSEL_PC_HI = 2'b10
    } stk_wsel_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int          AW     = 8,
    parameter logic [AW-1:0] RST_VAL = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic          ld_i,
    input  logic [AW-1:0] ld_val_i,
    output logic [AW-1:0] ptr_o,
    output logic [AW-1:0] ptr_up_o
);

    logic [AW-1:0] ptr_q;

    // software load first, then automatic moves; arithmetic wraps at AW bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= RST_VAL;
        end else if (ld_i) begin
            ptr_q <= ld_val_i;
        end else if (inc_i) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (dec_i) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    assign ptr_o    = ptr_q;
    assign ptr_up_o = ptr_q + 1'b1;

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // read data registered; holds its value between reads
    always_ff @(posedge clk) begin
        if (re_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld_i,
    input  logic [1:0]    cmd_op_i,
    input  logic [DW-1:0] pc_hi_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          we_o,
    output logic          re_o,
    output stk_wsel_e     wsel_o,
    output logic          inc_o,
    output logic          dec_o,
    output logic          busy_o,
    output logic          pop_vld_o,
    output logic          ret_vld_o,
    output logic [DW-1:0] pc_hi_q_o,
    output logic [DW-1:0] ret_hi_q_o
);

    stk_state_e    state_q, state_d;
    stk_op_e       op;
    logic          accept;
    logic          pop_vld_q, ret_vld_q;
    logic [DW-1:0] pc_hi_q, ret_hi_q;

    assign op     = stk_op_e'(cmd_op_i);
    assign accept = cmd_vld_i && (state_q == ST_IDLE);

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && op == OP_CALL) begin
                    state_d = ST_CALL_HI;
                end else if (accept && op == OP_RET) begin
                    state_d = ST_RET_LO;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_CALL_HI: state_d = ST_IDLE;
            ST_RET_LO:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs per state
    always_comb begin
        we_o   = 1'b0;
        re_o   = 1'b0;
        inc_o  = 1'b0;
        dec_o  = 1'b0;
        wsel_o = WSEL_DATA;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_vld_i) begin
                    unique case (op)
                        OP_PUSH: begin
                            we_o  = 1'b1;
                            inc_o = 1'b1;
                        end
                        OP_POP: begin
                            re_o  = 1'b1;
                            dec_o = 1'b1;
                        end
                        OP_CALL: begin
                            we_o   = 1'b1;
                            inc_o  = 1'b1;
                            wsel_o = WSEL_PC_LO;
                        end
                        OP_RET: begin
                            re_o  = 1'b1;
                            dec_o = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_CALL_HI: begin
                we_o   = 1'b1;
                inc_o  = 1'b1;
                wsel_o = WSEL_PC_HI;
            end
            ST_RET_LO: begin
                re_o  = 1'b1;
                dec_o = 1'b1;
            end
            default: ;
        endcase
    end

    // result strobes and byte holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_vld_q <= 1'b0;
            ret_vld_q <= 1'b0;
            pc_hi_q   <= '0;
            ret_hi_q  <= '0;
        end else begin
            pop_vld_q <= accept && (op == OP_POP);
            ret_vld_q <= (state_q == ST_RET_LO);
            if (accept && op == OP_CALL) begin
                pc_hi_q <= pc_hi_i;
            end
            if (state_q == ST_RET_LO) begin
                ret_hi_q <= rd_data_i;
            end
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign pop_vld_o  = pop_vld_q;
    assign ret_vld_o  = ret_vld_q;
    assign pc_hi_q_o  = pc_hi_q;
    assign ret_hi_q_o = ret_hi_q;

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
    import stk_pkg::*;
#(
    parameter int            AW      = 8,
    parameter int            DW      = 8,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [DW-1:0]     push_data_i,
    input  logic [2*DW-1:0]   pc_i,
    input  logic              sp_wr_i,
    input  logic [AW-1:0]     sp_wdata_i,
    output logic [AW-1:0]     sp_rdata_o,
    output logic [AW-1:0]     ram_addr_o,
    output logic [DW-1:0]     ram_wdata_o,
    output logic              ram_we_o,
    output logic [DW-1:0]     pop_data_o,
    output logic              pop_vld_o,
    output logic [2*DW-1:0]   ret_pc_o,
    output logic              ret_vld_o,
    output logic              busy_o
);

    localparam int PCW = 2 * DW;

    logic          we, re, inc, dec;
    stk_wsel_e     wsel;
    logic [AW-1:0] ptr, ptr_up, addr;
    logic [DW-1:0] wdata, rd_data, pc_hi_q, ret_hi_q;

    stk_ptr #(
        .AW      (AW),
        .RST_VAL (SP_INIT)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc),
        .dec_i    (dec),
        .ld_i     (sp_wr_i),
        .ld_val_i (sp_wdata_i),
        .ptr_o    (ptr),
        .ptr_up_o (ptr_up)
    );

    stk_seq #(
        .DW (DW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld_i  (cmd_vld_i),
        .cmd_op_i   (cmd_op_i),
        .pc_hi_i    (pc_i[PCW-1:DW]),
        .rd_data_i  (rd_data),
        .we_o       (we),
        .re_o       (re),
        .wsel_o     (wsel),
        .inc_o      (inc),
        .dec_o      (dec),
        .busy_o     (busy_o),
        .pop_vld_o  (pop_vld_o),
        .ret_vld_o  (ret_vld_o),
        .pc_hi_q_o  (pc_hi_q),
        .ret_hi_q_o (ret_hi_q)
    );

    // writes go one above the pointer, reads at the pointer
    assign addr = we ? ptr_up : ptr;

    always_comb begin
        unique case (wsel)
            WSEL_PC_LO: wdata = pc_i[DW-1:0];
            WSEL_PC_HI: wdata = pc_hi_q;
            default:    wdata = push_data_i;
        endcase
    end

    stk_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk     (clk),
        .we_i    (we),
        .re_i    (re),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rd_data)
    );

    assign sp_rdata_o  = ptr;
    assign ram_addr_o  = addr;
    assign ram_wdata_o = wdata;
    assign ram_we_o    = we;
    assign pop_data_o  = rd_data;
    assign ret_pc_o    = {ret_hi_q, rd_data};

endmodule

// File: rtl/stack_call_unit_chk.sv
module stack_call_unit_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_vld_i,
    input logic [1:0]    cmd_op_i,
    input logic          sp_wr_i,
    input logic [AW-1:0] sp_wdata_i,
    input logic [AW-1:0] sp_rdata_o,
    input logic [AW-1:0] ram_addr_o,
    input logic          ram_we_o,
    input logic          pop_vld_o,
    input logic          ret_vld_o,
    input logic          busy_o
);

    logic acc_push, acc_pop, acc_call, acc_ret;
    assign acc_push = cmd_vld_i && !busy_o && cmd_op_i == 2'b00;
    assign acc_pop  = cmd_vld_i && !busy_o && cmd_op_i == 2'b01;
    assign acc_call = cmd_vld_i && !busy_o && cmd_op_i == 2'b10;
    assign acc_ret  = cmd_vld_i && !busy_o && cmd_op_i == 2'b11;

    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_rdata_o == AW'(8'h07) && !busy_o && !ram_we_o));

    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push |-> (ram_we_o && ram_addr_o == AW'(sp_rdata_o + 1'b1)));

    p_push_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_push && !sp_wr_i) |=> (sp_rdata_o == AW'($past(sp_rdata_o) + 1'b1)));

    p_pop_decr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pop && !sp_wr_i) |=> (pop_vld_o && sp_rdata_o == AW'($past(sp_rdata_o) - 1'b1)));

    p_call_second_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_call |=> (busy_o && ram_we_o));

    p_ret_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ret |=> busy_o ##1 ret_vld_o);

    p_busy_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    p_busy_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !pop_vld_o);

    p_wrap_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_push && !sp_wr_i && sp_rdata_o == {AW{1'b1}}) |=> (sp_rdata_o == '0));

    p_sw_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_i |=> (sp_rdata_o == $past(sp_wdata_i)));

endmodule

bind stack_call_unit stack_call_unit_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_op_i   (cmd_op_i),
    .sp_wr_i    (sp_wr_i),
    .sp_wdata_i (sp_wdata_i),
    .sp_rdata_o (sp_rdata_o),
    .ram_addr_o (ram_addr_o),
    .ram_we_o   (ram_we_o),
    .pop_vld_o  (pop_vld_o),
    .ret_vld_o  (ret_vld_o),
    .busy_o     (busy_o)
);

// File: tb/stack_call_unit_tb_top.sv
module stack_call_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_vld_i;
    logic [1:0]  cmd_op_i;
    logic [7:0]  push_data_i;
    logic [15:0] pc_i;
    logic        sp_wr_i;
    logic [7:0]  sp_wdata_i;
    logic [7:0]  sp_rdata_o, ram_addr_o, ram_wdata_o, pop_data_o;
    logic        ram_we_o, pop_vld_o, ret_vld_o, busy_o;
    logic [15:0] ret_pc_o;

    always #2 clk = ~clk;

    stack_call_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i),
        .push_data_i(push_data_i), .pc_i(pc_i), .sp_wr_i(sp_wr_i), .sp_wdata_i(sp_wdata_i),
        .sp_rdata_o(sp_rdata_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
        .ram_we_o(ram_we_o), .pop_data_o(pop_data_o), .pop_vld_o(pop_vld_o),
        .ret_pc_o(ret_pc_o), .ret_vld_o(ret_vld_o), .busy_o(busy_o)
    );

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference model
    int          m_sp;
    logic [7:0]  m_mem [256];
    bit          m_known [256];
    int          m_st;        // 0 idle, 1 second call cycle, 2 second return cycle
    logic [7:0]  m_pch, m_reth;
    bit          m_rethk;
    bit          m_popv, m_popk, m_retv, m_retk;
    logic [7:0]  m_popd;
    logic [15:0] m_retpc;

    localparam logic [1:0] C_PUSH = 2'b00, C_POP = 2'b01, C_CALL = 2'b10, C_RET = 2'b11;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit vld, input logic [1:0] op, input logic [7:0] d,
                        input logic [15:0] pc, input bit swr, input logic [7:0] swd,
                        input string tag);
        bit         acc, we, rd;
        logic [7:0] exp_wd, rv;
        bit         rk;
        int         wa, nst;
        cmd_vld_i   = vld;
        cmd_op_i    = op;
        push_data_i = d;
        pc_i        = pc;
        sp_wr_i     = swr;
        sp_wdata_i  = swd;
        #1;
        acc    = vld && (m_st == 0);
        we     = (acc && (op == C_PUSH || op == C_CALL)) || (m_st == 1);
        rd     = (acc && (op == C_POP || op == C_RET)) || (m_st == 2);
        exp_wd = (m_st == 1) ? m_pch : ((op == C_CALL) ? pc[7:0] : d);
        wa     = (m_sp + 1) & 255;
        chk(sp_rdata_o == m_sp[7:0], tag, "pointer", sp_rdata_o, m_sp);
        chk(busy_o == (m_st != 0), tag, "busy", busy_o, m_st != 0);
        chk(ram_we_o == we, tag, "write enable", ram_we_o, we);
        if (we) begin
            chk(ram_addr_o == wa[7:0], tag, "write address", ram_addr_o, wa);
            chk(ram_wdata_o == exp_wd, tag, "write data", ram_wdata_o, exp_wd);
        end
        if (rd) chk(ram_addr_o == m_sp[7:0], tag, "read address", ram_addr_o, m_sp);
        chk(pop_vld_o == m_popv, tag, "pop valid", pop_vld_o, m_popv);
        if (m_popv && m_popk) chk(pop_data_o == m_popd, tag, "pop data", pop_data_o, m_popd);
        chk(ret_vld_o == m_retv, tag, "return valid", ret_vld_o, m_retv);
        if (m_retv && m_retk) chk(ret_pc_o == m_retpc, tag, "return pc", ret_pc_o, m_retpc);
        // advance the model to the state after the coming edge
        rv   = m_mem[m_sp];
        rk   = m_known[m_sp];
        m_popv = acc && (op == C_POP);
        m_popd = rv;
        m_popk = rk;
        m_retv  = (m_st == 2);
        m_retpc = {m_reth, rv};
        m_retk  = m_rethk && rk;
        nst = 0;
        if (acc && op == C_CALL) begin
            m_pch = pc[15:8];
            nst = 1;
        end
        if (acc && op == C_RET) begin
            m_reth  = rv;
            m_rethk = rk;
            nst = 2;
        end
        if (we) begin
            m_mem[wa]   = exp_wd;
            m_known[wa] = 1'b1;
        end
        if (swr)      m_sp = swd;
        else if (we)  m_sp = wa;
        else if (rd)  m_sp = (m_sp + 255) & 255;
        m_st = nst;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, C_PUSH, 8'h00, 16'h0000, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_vld_i = 1'b0; cmd_op_i = 2'b00; push_data_i = 8'h00; pc_i = 16'h0000;
        sp_wr_i = 1'b0; sp_wdata_i = 8'h00;
        m_sp = 7; m_st = 0; m_popv = 0; m_retv = 0; m_popk = 0; m_retk = 0; m_rethk = 0;
        m_pch = 8'h00; m_reth = 8'h00; m_popd = 8'h00; m_retpc = 16'h0000;
        for (int i = 0; i < 256; i++) begin
            m_known[i] = 1'b0;
            m_mem[i]   = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(sp_rdata_o == 8'h07, "R1", "reset pointer", sp_rdata_o, 8'h07);
        chk(!busy_o && !pop_vld_o && !ret_vld_o && !ram_we_o, "R1", "reset strobes",
            {busy_o, pop_vld_o, ret_vld_o, ram_we_o}, 0);
        @(negedge clk);
        idle("R1");

        // R2 R10: pushes land at 08h upward
        step(1'b1, C_PUSH, 8'h11, 16'h0, 1'b0, 8'h0, "R2 R10");
        step(1'b1, C_PUSH, 8'h22, 16'h0, 1'b0, 8'h0, "R2 R10");
        step(1'b1, C_PUSH, 8'h33, 16'h0, 1'b0, 8'h0, "R2 R10");
        // R3 R4: pops return in reverse order
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R3 R4");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R3 R4");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R3 R4");
        idle("R3 R4");
        // R10: no valid means no command
        step(1'b0, C_CALL, 8'h5A, 16'hAAAA, 1'b0, 8'h0, "R10");

        // R5 then a push during busy (R7)
        step(1'b1, C_CALL, 8'h0, 16'hBEEF, 1'b0, 8'h0, "R5");
        step(1'b1, C_PUSH, 8'h55, 16'h0, 1'b0, 8'h0, "R5 R7");
        idle("R5");
        // R6 then a pop during busy (R7)
        step(1'b1, C_RET, 8'h0, 16'h0, 1'b0, 8'h0, "R6");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R6 R7");
        idle("R6");
        idle("R6 R7");

        // R8: wrap upward and downward
        step(1'b0, C_PUSH, 8'h0, 16'h0, 1'b1, 8'hFF, "R8");
        step(1'b1, C_PUSH, 8'h77, 16'h0, 1'b0, 8'h0, "R8");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R8");
        step(1'b0, C_PUSH, 8'h0, 16'h0, 1'b1, 8'h00, "R8");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b0, 8'h0, "R8");
        idle("R8");
        step(1'b1, C_CALL, 8'h0, 16'hC0DE, 1'b0, 8'h0, "R8 R5");
        idle("R8 R5");
        step(1'b1, C_RET, 8'h0, 16'h0, 1'b0, 8'h0, "R8 R6");
        idle("R8 R6");
        idle("R8 R6");

        // R9: software load collides with a push and with a call second cycle
        step(1'b0, C_PUSH, 8'h0, 16'h0, 1'b1, 8'h20, "R9");
        step(1'b1, C_PUSH, 8'h99, 16'h0, 1'b1, 8'h40, "R9");
        step(1'b1, C_POP, 8'h0, 16'h0, 1'b1, 8'h21, "R9");
        step(1'b1, C_CALL, 8'h0, 16'h1234, 1'b0, 8'h0, "R9 R5");
        step(1'b0, C_PUSH, 8'h0, 16'h0, 1'b1, 8'h60, "R9 R5");
        idle("R9");

        // mixed traffic
        step(1'b0, C_PUSH, 8'h0, 16'h0, 1'b1, 8'h30, "R4");
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], r[15:8], r[31:16], (r[7:4] == 4'h0), r[23:16], "R4 R7 R9");
        end
        idle("R4");
        idle("R4");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule